// File: doc/BRIEF.md
# Floppy Controller Read-ID Sequencer

This block carries out the "read the next sector header" command of a floppy disk controller. When a command is accepted it latches the drive and head selection from the command argument byte and the data-rate selection. It then enables an internal clock-enable whose period is a rate-dependent number of oscillator cycles. With that clock running, it watches an already-decoded stream of address-mark strobes and header bytes. The first ID address mark it sees opens a capture of the next four header bytes: cylinder, head, sector and size code. Once all four are stored, the command completes with normal status.

The rotating medium also produces an index pulse once per revolution. Pulses that are too short are rejected. A pulse counts only after it has stayed high for a minimum number of internal clock periods. If the second qualified index pulse arrives while no ID mark has yet been seen, the command ends with an abnormal-termination code and a missing-address-mark flag. Either ending raises a single-cycle completion interrupt and drops busy. A new command can be issued in the very cycle that the interrupt is visible.

Top module: `rdid_seq`

## Requirements
- R1: After synchronous reset, busy, irq, int_tick, st0, st1 and id_field are all zero.
- R2: On acceptance, bit 2 of cmd_arg selects the head. The head appears on head_sel and in st0 bit 2, and cmd_arg[1:0] appears in st0[1:0].
- R3: After an ID address mark, the next four byte strobes are stored into id_field, first byte in bits [31:24]. The command then completes with st0[7:6]=00 and st1=0. Byte strobes seen before the mark are ignored.
- R4: If the second qualified index pulse comes before any ID mark, the command ends with st0[7:6]=01 and st1=8'h01 (bit 0 is the missing-mark flag). id_field keeps its previous value.
- R5: A single qualified index pulse does not end the command.
- R6: An index pulse shorter than 5 internal clock periods is not counted.
- R7: The internal clock period is 6, 10, 12 or 3 oscillator cycles for rate_sel 00, 01, 10 and 11 respectively (500, 300, 250 kbps and 1 Mbps).
- R8: irq is high for exactly one cycle per command. busy falls in that same cycle.
- R9: cmd_valid is ignored while busy; head_sel and the final st0 keep the values of the running command.
- R10: int_tick stays low while the block is idle.
- R11: A cmd_valid driven during the cycle in which irq is high is accepted, and busy is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command with cmd_arg and rate_sel |
| cmd_arg | input | 8 | Second command byte: [2] head, [1:0] drive |
| rate_sel | input | 2 | Data-rate code sampled at command start |
| index_in | input | 1 | Asynchronous index pulse from the drive |
| mark_stb | input | 1 | Decoded ID address mark seen |
| byte_stb | input | 1 | Decoded header byte present on byte_in |
| byte_in | input | 8 | Decoded header byte |
| busy | output | 1 | Command in progress |
| irq | output | 1 | One-cycle completion interrupt |
| head_sel | output | 1 | Head of the current or last command |
| int_tick | output | 1 | Internal clock-enable pulse |
| st0 | output | 8 | Status 0: [7:6] end code, [2] head, [1:0] drive |
| st1 | output | 8 | Status 1: [0] missing address mark |
| id_field | output | 32 | Captured cylinder, head, sector, size |

## Verification
Completion and command acceptance can coincide. In the cycle where irq is high, busy is already low, so a cmd_valid presented then starts the next command at the same edge that the previous one's interrupt is being read. The bench drives cmd_valid at the falling edge where it observes irq and checks busy one cycle later. The scoreboard must still see exactly one completion for the old command and, later, the correct status for the new one. The new command is then ended by index failure, which also shows that its index count started fresh.

// File: rtl/rdid_pkg.sv
package rdid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_CAPT = 2'd2
  } seq_state_e;

  localparam logic [1:0] END_NORMAL   = 2'b00;
  localparam logic [1:0] END_ABNORMAL = 2'b01;
  localparam logic [7:0] ST1_NO_MARK  = 8'h01;
endpackage

// File: rtl/rdid_clkdiv.sv
module rdid_clkdiv #(
  parameter int D0 = 6,
  parameter int D1 = 10,
  parameter int D2 = 12,
  parameter int D3 = 3,
  parameter int W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  always_comb begin
    case (rate)
      2'd0:    lim = W'(D0 - 1);
      2'd1:    lim = W'(D1 - 1);
      2'd2:    lim = W'(D2 - 1);
      default: lim = W'(D3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rdid_index_qual.sv
module rdid_index_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_TICKS   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic index_in,
  output logic idx_ok
);
  localparam int CW = $clog2(MIN_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          width_q;
  logic                   lvl;

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], index_in};
  end

  // Width is measured in internal clock periods; one qualified pulse per high phase.
  always_ff @(posedge clk) begin
    if (rst || !en || !lvl) begin
      width_q <= '0;
      idx_ok  <= 1'b0;
    end else begin
      idx_ok <= 1'b0;
      if (tick && (width_q < CW'(MIN_TICKS))) begin
        width_q <= width_q + 1'b1;
        if (width_q == CW'(MIN_TICKS - 1)) idx_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdid_ctrl.sv
module rdid_ctrl
  import rdid_pkg::*;
#(
  parameter int IDX_LIMIT = 2,
  parameter int ID_BYTES  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_arg,
  input  logic [1:0]            rate_sel,
  input  logic                  idx_ok,
  input  logic                  mark_stb,
  input  logic                  byte_stb,
  input  logic [7:0]            byte_in,
  output logic                  busy,
  output logic                  irq,
  output logic                  head_sel,
  output logic [1:0]            rate_q,
  output logic [7:0]            st0,
  output logic [7:0]            st1,
  output logic [ID_BYTES*8-1:0] id_field
);
  localparam int IW = $clog2(IDX_LIMIT + 1);
  localparam int BW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  seq_state_e    state;
  logic [IW-1:0] idx_cnt;
  logic [BW-1:0] byte_cnt;
  logic [1:0]    drv_q;
  logic [7:0]    id_q [ID_BYTES];
  logic          unused_arg;

  assign unused_arg = ^cmd_arg[7:3];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_idout
    assign id_field[ID_BYTES*8-1-8*g -: 8] = id_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      irq      <= 1'b0;
      head_sel <= 1'b0;
      drv_q    <= '0;
      rate_q   <= '0;
      st0      <= '0;
      st1      <= '0;
      idx_cnt  <= '0;
      byte_cnt <= '0;
      for (int i = 0; i < ID_BYTES; i++) id_q[i] <= '0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            head_sel <= cmd_arg[2];
            drv_q    <= cmd_arg[1:0];
            rate_q   <= rate_sel;
            idx_cnt  <= '0;
            st0      <= '0;
            st1      <= '0;
            busy     <= 1'b1;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (mark_stb) begin
            byte_cnt <= '0;
            state    <= ST_CAPT;
          end else if (idx_ok) begin
            if (idx_cnt == IW'(IDX_LIMIT - 1)) begin
              st0   <= {END_ABNORMAL, 3'b000, head_sel, drv_q};
              st1   <= ST1_NO_MARK;
              irq   <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              idx_cnt <= idx_cnt + 1'b1;
            end
          end
        end
        ST_CAPT: begin
          if (byte_stb) begin
            id_q[byte_cnt] <= byte_in;
            if (byte_cnt == BW'(ID_BYTES - 1)) begin
              st0   <= {END_NORMAL, 3'b000, head_sel, drv_q};
              st1   <= '0;
              irq   <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              byte_cnt <= byte_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdid_seq.sv
module rdid_seq #(
  parameter int DIV_500K    = 6,
  parameter int DIV_300K    = 10,
  parameter int DIV_250K    = 12,
  parameter int DIV_1M      = 3,
  parameter int MIN_IDX_TCK = 5,
  parameter int IDX_LIMIT   = 2,
  parameter int ID_BYTES    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_arg,
  input  logic [1:0]            rate_sel,
  input  logic                  index_in,
  input  logic                  mark_stb,
  input  logic                  byte_stb,
  input  logic [7:0]            byte_in,
  output logic                  busy,
  output logic                  irq,
  output logic                  head_sel,
  output logic                  int_tick,
  output logic [7:0]            st0,
  output logic [7:0]            st1,
  output logic [ID_BYTES*8-1:0] id_field
);
  localparam int MAXD_A = (DIV_500K > DIV_300K) ? DIV_500K : DIV_300K;
  localparam int MAXD_B = (DIV_250K > DIV_1M) ? DIV_250K : DIV_1M;
  localparam int MAXD   = (MAXD_A > MAXD_B) ? MAXD_A : MAXD_B;
  localparam int DW     = $clog2(MAXD + 1);

  logic [1:0] rate_q;
  logic       idx_ok;

  rdid_clkdiv #(
    .D0(DIV_500K), .D1(DIV_300K), .D2(DIV_250K), .D3(DIV_1M), .W(DW)
  ) u_div (
    .clk(clk), .rst(rst), .en(busy), .rate(rate_q), .tick(int_tick)
  );

  rdid_index_qual #(
    .SYNC_STAGES(SYNC_STAGES), .MIN_TICKS(MIN_IDX_TCK)
  ) u_idx (
    .clk(clk), .rst(rst), .en(busy), .tick(int_tick),
    .index_in(index_in), .idx_ok(idx_ok)
  );

  rdid_ctrl #(
    .IDX_LIMIT(IDX_LIMIT), .ID_BYTES(ID_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_arg(cmd_arg),
    .rate_sel(rate_sel), .idx_ok(idx_ok), .mark_stb(mark_stb),
    .byte_stb(byte_stb), .byte_in(byte_in), .busy(busy), .irq(irq),
    .head_sel(head_sel), .rate_q(rate_q), .st0(st0), .st1(st1),
    .id_field(id_field)
  );
endmodule

// File: rtl/rdid_seq_chk.sv
module rdid_seq_chk #(
  parameter int D0 = 6,
  parameter int D1 = 10,
  parameter int D2 = 12,
  parameter int D3 = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       irq,
  input logic       head_sel,
  input logic       int_tick,
  input logic [1:0] rate_q,
  input logic [7:0] st0,
  input logic [7:0] st1
);
  logic [7:0] gap_q;
  logic       seen_q;
  logic [7:0] exp_div;

  always_comb begin
    case (rate_q)
      2'd0:    exp_div = 8'(D0);
      2'd1:    exp_div = 8'(D1);
      2'd2:    exp_div = 8'(D2);
      default: exp_div = 8'(D3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (int_tick) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hFF) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst) (busy && int_tick && seen_q) |-> (gap_q == exp_div)); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R8
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) irq |-> !busy); // R8
  AST_BUSY_END_IRQ: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> irq); // R8
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (rst) (irq && st1 == 8'h01) |-> (st0[7:6] == 2'b01)); // R4
  AST_OK_CODE: assert property (@(posedge clk) disable iff (rst) (irq && st1 == 8'h00) |-> (st0[7:6] == 2'b00)); // R3
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(head_sel)); // R9
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst) !busy |=> !int_tick); // R10
endmodule

bind rdid_seq rdid_seq_chk #(
  .D0(DIV_500K), .D1(DIV_300K), .D2(DIV_250K), .D3(DIV_1M)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .irq(irq), .head_sel(head_sel),
  .int_tick(int_tick), .rate_q(rate_q), .st0(st0), .st1(st1)
);

// File: tb/rdid_seq_tb_top.sv
module rdid_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  st0;
    logic [7:0]  st1;
    logic [31:0] id;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_arg = '0;
  logic [1:0]  rate_sel = '0;
  logic        index_in = 1'b0;
  logic        mark_stb = 1'b0;
  logic        byte_stb = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        busy, irq, head_sel, int_tick;
  logic [7:0]  st0, st1;
  logic [31:0] id_field;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic prev_irq = 1'b0;
  logic [31:0] last_id = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdid_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_arg(cmd_arg),
    .rate_sel(rate_sel), .index_in(index_in), .mark_stb(mark_stb),
    .byte_stb(byte_stb), .byte_in(byte_in), .busy(busy), .irq(irq),
    .head_sel(head_sel), .int_tick(int_tick), .st0(st0), .st1(st1),
    .id_field(id_field)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Monitor: pops one expectation per completion interrupt.
  always @(negedge clk) begin
    if (!rst) begin
      if (irq) begin
        check(!busy, "R8 busy low with irq", 32'(busy), 32'd0);
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected irq", 32'(irq), 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(st0 == e.st0, {e.tag, " st0"}, 32'(st0), 32'(e.st0));
          check(st1 == e.st1, {e.tag, " st1"}, 32'(st1), 32'(e.st1));
          check(id_field == e.id, {e.tag, " id"}, id_field, e.id);
        end
      end
      if (irq && prev_irq) check(1'b0, "R8 irq longer than one cycle", 32'd2, 32'd1);
      prev_irq = irq;
    end
  end

  task automatic expect_done(input logic [7:0] arg, input bit fail, input logic [31:0] id, input string tag);
    exp_t e;
    e.st0 = {fail ? 2'b01 : 2'b00, 3'b000, arg[2], arg[1:0]};
    e.st1 = fail ? 8'h01 : 8'h00;
    e.id  = id;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic start_cmd(input logic [7:0] arg, input logic [1:0] rate);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_arg = arg; rate_sel = rate;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_index(input int high, input int low);
    index_in = 1'b1;
    repeat (high) @(negedge clk);
    index_in = 1'b0;
    repeat (low) @(negedge clk);
  endtask

  // Sends mark then header bytes; returns at the falling edge where irq is visible.
  task automatic send_id(input logic [31:0] id);
    @(negedge clk);
    mark_stb = 1'b1;
    @(negedge clk);
    mark_stb = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byte_stb = 1'b1; byte_in = id[31-8*i -: 8];
      @(negedge clk);
      byte_stb = 1'b0;
    end
    last_id = id;
  endtask

  task automatic measure_tick(input int expd, input string tag);
    int n;
    while (!int_tick) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!int_tick && n < 100);
    check(n == expd, tag, 32'(n), 32'(expd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int idle_ticks;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && irq == 0, "R1 busy/irq after reset", {30'd0, busy, irq}, 32'd0);
    check(st0 == 0 && st1 == 0, "R1 status after reset", {16'd0, st0, st1}, 32'd0);
    check(id_field == 0 && int_tick == 0, "R1 id/tick after reset", id_field, 32'd0);

    // R10: no internal ticks while idle
    idle_ticks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int_tick) idle_ticks++;
    end
    check(idle_ticks == 0, "R10 idle ticks", 32'(idle_ticks), 32'd0);

    // R7 tick period at each rate, R2 head/drive, R3 success, R5 single index, R3 pre-mark bytes ignored
    expect_done(8'h06, 1'b0, 32'h11223344, "R2 R3 R5 rate0 success");
    start_cmd(8'h06, 2'd0);
    check(head_sel == 1'b1, "R2 head_sel", 32'(head_sel), 32'd1);
    measure_tick(6, "R7 rate 00 period");
    pulse_index(100, 60);
    check(busy == 1'b1, "R5 one index keeps busy", 32'(busy), 32'd1);
    @(negedge clk); byte_stb = 1'b1; byte_in = 8'hEE;
    @(negedge clk); byte_stb = 1'b0;
    send_id(32'h11223344);
    repeat (3) @(negedge clk);

    expect_done(8'h01, 1'b0, 32'hA0B1C2D3, "R7 rate01 success");
    start_cmd(8'h01, 2'd1);
    measure_tick(10, "R7 rate 01 period");
    send_id(32'hA0B1C2D3);
    repeat (3) @(negedge clk);

    expect_done(8'h02, 1'b0, 32'h01020304, "R7 rate10 success");
    start_cmd(8'h02, 2'd2);
    measure_tick(12, "R7 rate 10 period");
    send_id(32'h01020304);
    repeat (3) @(negedge clk);

    expect_done(8'h07, 1'b0, 32'h55667788, "R7 rate11 success");
    start_cmd(8'h07, 2'd3);
    measure_tick(3, "R7 rate 11 period");
    send_id(32'h55667788);
    repeat (3) @(negedge clk);

    // R4 failure after two qualified index pulses; id kept
    expect_done(8'h01, 1'b1, 32'h55667788, "R4 index failure");
    start_cmd(8'h01, 2'd0);
    pulse_index(100, 60);
    pulse_index(100, 20);
    check(busy == 1'b0, "R4 busy after failure", 32'(busy), 32'd0);

    // R6 short pulses are not counted
    expect_done(8'h00, 1'b0, 32'h0A0B0C0D, "R6 short pulses ignored");
    start_cmd(8'h00, 2'd0);
    for (int i = 0; i < 3; i++) pulse_index(20, 40);
    check(busy == 1'b1, "R6 busy after short pulses", 32'(busy), 32'd1);
    send_id(32'h0A0B0C0D);
    repeat (3) @(negedge clk);

    // R7 same pulse width qualifies at 1 Mbps but not at 250 kbps
    expect_done(8'h03, 1'b1, 32'h0A0B0C0D, "R7 fast rate counts 30-cycle pulses");
    start_cmd(8'h03, 2'd3);
    pulse_index(30, 40);
    pulse_index(30, 40);
    check(busy == 1'b0, "R7 fast rate failed", 32'(busy), 32'd0);
    expect_done(8'h02, 1'b0, 32'hCAFE0102, "R7 slow rate rejects 30-cycle pulses");
    start_cmd(8'h02, 2'd2);
    pulse_index(30, 40);
    pulse_index(30, 40);
    check(busy == 1'b1, "R7 slow rate still busy", 32'(busy), 32'd1);
    send_id(32'hCAFE0102);
    repeat (3) @(negedge clk);

    // R9 refusal while busy, R11 acceptance in the irq cycle
    expect_done(8'h04, 1'b0, 32'hDEADBEEF, "R9 first command status");
    expect_done(8'h02, 1'b1, 32'hDEADBEEF, "R11 chained command failure");
    start_cmd(8'h04, 2'd0);
    start_cmd(8'h02, 2'd0);
    check(head_sel == 1'b1, "R9 head held while busy", 32'(head_sel), 32'd1);
    send_id(32'hDEADBEEF);
    check(irq == 1'b1, "R11 irq visible", 32'(irq), 32'd1);
    cmd_valid = 1'b1; cmd_arg = 8'h02; rate_sel = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R11 busy after chained start", 32'(busy), 32'd1);
    check(head_sel == 1'b0, "R11 new head", 32'(head_sel), 32'd0);
    pulse_index(100, 60);
    pulse_index(100, 20);

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R8 all completions seen", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule